// File: doc/BRIEF.md
# Branch Condition Code Evaluator

This block takes a 4-bit condition selector and the processor status flags (zero, sign, overflow, carry and sticky saturation). It reports combinationally whether the selected condition holds. The same answer comes out in two forms: a single condition bit, and a 32-bit word that holds the bit in its least significant position with zeros above it. The word is meant for an instruction that writes a condition flag into a general register.

The block also forms the next program counter for short relative branches. When the branch strobe is high, the register captures one of two values on the rising clock edge. If the condition holds, it takes the current PC plus a sign-extended 9-bit displacement. If the condition fails, it takes the current PC plus two. The displacement's lowest bit is forced to zero so that targets stay halfword aligned. When the strobe is low, the register keeps its value. An active-low synchronous reset clears it.

Selectors 0 to 7 are the primary conditions. Selectors 8 to 15 mostly invert their partner 8 below. Selector 13 is the exception: it tests the saturation flag and is not the inverse of the always-true selector 5.

Top module: `cond_branch_unit`

## Requirements
- R1: Selector 0 is true when OV=1, 1 when CY=1, 2 when Z=1, 3 when CY or Z is 1, and 4 when S=1.
- R2: Selector 6 is true when S xor OV is 1. Selector 7 is true when (S xor OV) or Z is 1.
- R3: Selectors 8, 9, 10, 11, 12, 14 and 15 each give the inverse of selector 0, 1, 2, 3, 4, 6 and 7 respectively.
- R4: Selector 5 is always true. Selector 13 equals the SAT flag, whatever the other flags are.
- R5: setfResult bit 0 equals condBit, and bits 31 to 1 are zero, for every selector and flag pattern.
- R6: With brValid=1 and the condition true, nextPc after the rising edge equals curPc plus the sign-extended displacement (disp bit 8 is the sign).
- R7: With brValid=1 and the condition false, nextPc after the rising edge equals curPc + 2.
- R8: With brValid=0, nextPc keeps its value across edges, whatever curPc, disp and the condition do.
- R9: With rstN=0 at a rising edge, nextPc becomes 0 after that edge, even when brValid=1.
- R10: disp bit 0 has no effect. An odd displacement produces the same target as that displacement with bit 0 cleared.
- R11: The PC arithmetic wraps modulo 2^32 both for taken branches and for the +2 step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| condCode | input | 4 | Condition selector |
| flagZ | input | 1 | Zero flag |
| flagS | input | 1 | Sign flag |
| flagOv | input | 1 | Overflow flag |
| flagCy | input | 1 | Carry flag |
| flagSat | input | 1 | Sticky saturation flag |
| curPc | input | 32 | Address of the current branch |
| disp | input | 9 | Signed branch displacement, bit 0 ignored |
| brValid | input | 1 | Branch strobe; loads nextPc on the edge |
| condBit | output | 1 | Selected condition holds |
| setfResult | output | 32 | condBit zero-extended to 32 bits |
| nextPc | output | 32 | Registered next program counter |

## Verification
The hardest situation to reach is one where selector 13 and the always-true selector 5 are told apart under flag patterns that would mislead a plain inversion rule. Another is a target that crosses the top or bottom of the address space. A vector table covers every selector with flags chosen so that the plain and inverted meanings disagree. An exhaustive sweep then drives all 512 selector and flag combinations against a reference model. Directed branch cycles use curPc near 0 and near 0xFFFFFFFE with the largest negative displacement, odd displacements and a reset asserted together with the strobe.

// File: rtl/cond_branch_pkg.sv
package cond_branch_pkg;

  // Status flags as seen by the evaluator
  typedef struct packed {
    logic z;
    logic s;
    logic ov;
    logic cy;
    logic sat;
  } statusFlags_t;

  // Strobes from control to the PC datapath
  typedef struct packed {
    logic loadPc;
    logic takeBranch;
  } pcCtrl_t;

  // Selector whose upper-half meaning is not an inversion
  localparam logic [3:0] SEL_SAT    = 4'hD;
  localparam logic [2:0] SEL_ALWAYS = 3'd5;

endpackage

// File: rtl/cond_branch_ctrl.sv
module cond_branch_ctrl
  import cond_branch_pkg::*;
#(
  parameter int CC_W = 4
) (
  input  logic [CC_W-1:0] condCode,
  input  statusFlags_t    flags,
  input  logic            brValid,
  output logic            condBit,
  output pcCtrl_t         ctrl
);

  localparam int BASE_N = 1 << (CC_W - 1);

  logic [BASE_N-1:0] baseHit;
  logic              signedLess;
  logic              baseSel;
  logic              invertSel;

  assign signedLess = flags.s ^ flags.ov;

  // Primary condition table, indexed by the low selector bits
  always_comb begin
    baseHit    = '0;
    baseHit[0] = flags.ov;
    baseHit[1] = flags.cy;
    baseHit[2] = flags.z;
    baseHit[3] = flags.cy | flags.z;
    baseHit[4] = flags.s;
    baseHit[5] = 1'b1;
    baseHit[6] = signedLess;
    baseHit[7] = signedLess | flags.z;
  end

  assign baseSel   = baseHit[condCode[CC_W-2:0]];
  assign invertSel = condCode[CC_W-1];

  always_comb begin
    if (condCode == SEL_SAT) condBit = flags.sat;
    else                     condBit = baseSel ^ invertSel;
  end

  assign ctrl.loadPc     = brValid;
  assign ctrl.takeBranch = condBit;

endmodule

// File: rtl/cond_branch_dp.sv
module cond_branch_dp
  import cond_branch_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DISP_W = 9,
  parameter int RES_W  = 32,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcCtrl_t           ctrl,
  input  logic              condBit,
  input  logic [PC_W-1:0]   curPc,
  input  logic [DISP_W-1:0] disp,
  output logic [RES_W-1:0]  setfResult,
  output logic [PC_W-1:0]   nextPc
);

  localparam int EXT_W = PC_W - DISP_W;
  localparam logic [PC_W-1:0] ALIGN_MASK = ~(PC_W'(1));

  logic [PC_W-1:0] dispFull;
  logic [PC_W-1:0] dispAligned;
  logic [PC_W-1:0] takenPc;
  logic [PC_W-1:0] seqPc;
  logic [PC_W-1:0] pcD;

  assign dispFull    = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign dispAligned = dispFull & ALIGN_MASK;
  assign takenPc     = curPc + dispAligned;
  assign seqPc       = curPc + PC_W'(STEP);
  assign pcD         = ctrl.takeBranch ? takenPc : seqPc;

  always_ff @(posedge clk) begin
    if (!rstN)            nextPc <= '0;
    else if (ctrl.loadPc) nextPc <= pcD;
  end

  assign setfResult = {{(RES_W-1){1'b0}}, condBit};

endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import cond_branch_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DISP_W = 9,
  parameter int CC_W   = 4,
  parameter int RES_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CC_W-1:0]   condCode,
  input  logic              flagZ,
  input  logic              flagS,
  input  logic              flagOv,
  input  logic              flagCy,
  input  logic              flagSat,
  input  logic [PC_W-1:0]   curPc,
  input  logic [DISP_W-1:0] disp,
  input  logic              brValid,
  output logic              condBit,
  output logic [RES_W-1:0]  setfResult,
  output logic [PC_W-1:0]   nextPc
);

  statusFlags_t flags;
  pcCtrl_t      ctrl;

  assign flags = '{z: flagZ, s: flagS, ov: flagOv, cy: flagCy, sat: flagSat};

  cond_branch_ctrl #(.CC_W(CC_W)) u_ctrl (
    .condCode (condCode),
    .flags    (flags),
    .brValid  (brValid),
    .condBit  (condBit),
    .ctrl     (ctrl)
  );

  cond_branch_dp #(
    .PC_W   (PC_W),
    .DISP_W (DISP_W),
    .RES_W  (RES_W),
    .STEP   (2)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .condBit    (condBit),
    .curPc      (curPc),
    .disp       (disp),
    .setfResult (setfResult),
    .nextPc     (nextPc)
  );

endmodule

// File: rtl/cond_branch_unit_chk.sv
module cond_branch_unit_chk #(
  parameter int PC_W  = 32,
  parameter int CC_W  = 4,
  parameter int RES_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [CC_W-1:0]  condCode,
  input logic             flagSat,
  input logic [PC_W-1:0]  curPc,
  input logic             brValid,
  input logic             condBit,
  input logic [RES_W-1:0] setfResult,
  input logic [PC_W-1:0]  nextPc
);

  a_r9_sync_clear: assert property (@(posedge clk)
    !rstN |=> nextPc == '0);

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !brValid |=> $stable(nextPc));

  a_r7_fallthrough: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && !condBit) |=> nextPc == $past(curPc) + PC_W'(2));

  a_r10_aligned_target: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && !curPc[0]) |=> !nextPc[0]);

  a_r5_zero_extend: assert property (@(posedge clk) disable iff (!rstN)
    ((setfResult >> 1) == '0) && (setfResult[0] == condBit));

  a_r4_always_true: assert property (@(posedge clk) disable iff (!rstN)
    (condCode == CC_W'(5)) |-> condBit);

  a_r4_sat_select: assert property (@(posedge clk) disable iff (!rstN)
    (condCode == CC_W'(13)) |-> (condBit == flagSat));

endmodule

bind cond_branch_unit cond_branch_unit_chk #(
  .PC_W  (PC_W),
  .CC_W  (CC_W),
  .RES_W (RES_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .condCode   (condCode),
  .flagSat    (flagSat),
  .curPc      (curPc),
  .brValid    (brValid),
  .condBit    (condBit),
  .setfResult (setfResult),
  .nextPc     (nextPc)
);

// File: tb/cond_branch_unit_tb.sv
module cond_branch_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  condCode = '0;
  logic        flagZ = 1'b0, flagS = 1'b0, flagOv = 1'b0, flagCy = 1'b0, flagSat = 1'b0;
  logic [31:0] curPc = '0;
  logic [8:0]  disp = '0;
  logic        brValid = 1'b0;
  logic        condBit;
  logic [31:0] setfResult;
  logic [31:0] nextPc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cond_branch_unit u_dut (
    .clk(clk), .rstN(rstN), .condCode(condCode),
    .flagZ(flagZ), .flagS(flagS), .flagOv(flagOv), .flagCy(flagCy), .flagSat(flagSat),
    .curPc(curPc), .disp(disp), .brValid(brValid),
    .condBit(condBit), .setfResult(setfResult), .nextPc(nextPc)
  );

  // {code[3:0], z, s, ov, cy, sat, expected}
  localparam int NVEC = 20;
  localparam logic [9:0] VEC [NVEC] = '{
    {4'h0, 5'b00100, 1'b1}, {4'h0, 5'b11011, 1'b0},
    {4'h1, 5'b00010, 1'b1}, {4'h2, 5'b10000, 1'b1},
    {4'h3, 5'b00000, 1'b0}, {4'h3, 5'b10000, 1'b1},
    {4'h4, 5'b01000, 1'b1}, {4'h5, 5'b00000, 1'b1},
    {4'h6, 5'b01100, 1'b0}, {4'h6, 5'b00100, 1'b1},
    {4'h7, 5'b10000, 1'b1}, {4'h7, 5'b01100, 1'b0},
    {4'h8, 5'b00000, 1'b1}, {4'h9, 5'b00010, 1'b0},
    {4'hA, 5'b00000, 1'b1}, {4'hB, 5'b00010, 1'b0},
    {4'hC, 5'b01000, 1'b0}, {4'hD, 5'b00001, 1'b1},
    {4'hD, 5'b11110, 1'b0}, {4'hE, 5'b01100, 1'b1}
  };

  function automatic string tagOf(input logic [3:0] c);
    if (c == 4'h5 || c == 4'hD) return "R4";
    if (c[3])                   return "R3";
    if (c == 4'h6 || c == 4'h7) return "R2";
    return "R1";
  endfunction

  function automatic logic refCond(input logic [3:0] c, input logic [4:0] f);
    logic z, s, ov, cy, sat, b;
    {z, s, ov, cy, sat} = f;
    case (c[2:0])
      3'd0: b = ov;
      3'd1: b = cy;
      3'd2: b = z;
      3'd3: b = cy | z;
      3'd4: b = s;
      3'd5: b = 1'b1;
      3'd6: b = s ^ ov;
      default: b = (s ^ ov) | z;
    endcase
    if (c == 4'hD) return sat;
    return c[3] ? ~b : b;
  endfunction

  function automatic logic [31:0] sext9(input logic [8:0] d);
    return {{23{d[8]}}, d[8:1], 1'b0};
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setFlags(input logic [4:0] f);
    {flagZ, flagS, flagOv, flagCy, flagSat} = f;
  endtask

  // One strobed branch cycle; nextPc sampled at the following falling edge
  task automatic branchCycle(input logic [3:0] c, input logic [4:0] f,
                             input logic [31:0] pc, input logic [8:0] d);
    @(negedge clk);
    condCode = c; setFlags(f); curPc = pc; disp = d; brValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    brValid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    // R9: reset clears nextPc, even with strobe high
    rstN = 1'b0; brValid = 1'b1; curPc = 32'h1234_5670; condCode = 4'h5;
    repeat (3) @(negedge clk);
    check32("R9 reset state", nextPc, 32'h0);
    brValid = 1'b0;
    rstN = 1'b1;

    // Table of selector vectors (R1..R5)
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      condCode = VEC[i][9:6];
      setFlags(VEC[i][5:1]);
      #1;
      check32(tagOf(VEC[i][9:6]), {31'b0, condBit}, {31'b0, VEC[i][0]});
      check32("R5 table zero-extend", setfResult, {31'b0, VEC[i][0]});
    end

    // Exhaustive sweep against reference (R1 R2 R3 R4 R5)
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 32; f++) begin
        @(negedge clk);
        condCode = 4'(c);
        setFlags(5'(f));
        #1;
        check32(tagOf(4'(c)), {31'b0, condBit}, {31'b0, refCond(4'(c), 5'(f))});
        check32("R5 sweep zero-extend", setfResult, {31'b0, refCond(4'(c), 5'(f))});
      end
    end

    // R6: taken branches, positive and negative
    branchCycle(4'h5, 5'b00000, 32'h0000_1000, 9'h010);
    check32("R6 taken +16", nextPc, 32'h0000_1010);
    branchCycle(4'h2, 5'b10000, 32'h0000_1000, 9'h1F0);
    check32("R6 taken -16", nextPc, 32'h0000_0FF0);
    branchCycle(4'h5, 5'b00000, 32'h0000_1000, 9'h100);
    check32("R6 taken most negative", nextPc, 32'h0000_1000 + sext9(9'h100));
    branchCycle(4'hD, 5'b00001, 32'h0000_2000, 9'h0FE);
    check32("R6 taken on SAT", nextPc, 32'h0000_20FE);

    // R10: odd displacement acts as even
    branchCycle(4'h5, 5'b00000, 32'h0000_1000, 9'h013);
    check32("R10 odd disp", nextPc, 32'h0000_1012);
    branchCycle(4'h5, 5'b00000, 32'h0000_1000, 9'h1FF);
    check32("R10 odd negative disp", nextPc, 32'h0000_0FFE);

    // R7: not taken steps by 2
    branchCycle(4'h0, 5'b11011, 32'h0000_2000, 9'h040);
    check32("R7 fall through", nextPc, 32'h0000_2002);
    branchCycle(4'hD, 5'b11110, 32'h0000_3000, 9'h040);
    check32("R7 SAT clear falls through", nextPc, 32'h0000_3002);

    // R11: wraparound
    branchCycle(4'h8, 5'b00100, 32'hFFFF_FFFE, 9'h020);
    check32("R11 step wraps", nextPc, 32'h0000_0000);
    branchCycle(4'h5, 5'b00000, 32'h0000_0004, 9'h1F0);
    check32("R11 backward wraps", nextPc, 32'hFFFF_FFF4);
    branchCycle(4'h5, 5'b00000, 32'hFFFF_FF80, 9'h0FE);
    check32("R11 forward wraps", nextPc, 32'h0000_007E);

    // R8: hold with strobe low while inputs change
    branchCycle(4'h5, 5'b00000, 32'h0000_4000, 9'h008);
    held = nextPc;
    check32("R8 preload", held, 32'h0000_4008);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      brValid = 1'b0; curPc = 32'h0000_9000 + 32'(k * 64); disp = 9'(k * 7); condCode = 4'(k);
    end
    @(negedge clk);
    check32("R8 hold", nextPc, held);

    // R9: reset during a strobed cycle wins
    @(negedge clk);
    brValid = 1'b1; condCode = 4'h5; curPc = 32'h0000_5000; disp = 9'h010; rstN = 1'b0;
    @(negedge clk);
    check32("R9 reset beats strobe", nextPc, 32'h0);
    rstN = 1'b1; brValid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule